// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address for 4 KB pages by reading a page directory entry and then a page table entry from memory. A requester hands over one translation at a time on a valid/ready handshake. The request carries the linear address, a write flag and a user-mode flag. The walker reads entries over a word-wide request/acknowledge memory port. It checks the presence and permission bits at both levels. On a successful walk it writes the entries back with their accessed and dirty flags updated. It then returns either the physical address or a fault with its cause.

The directory base comes from a control-register style input. Two enable inputs decide whether translation happens at all. When paging is not in force, the address passes straight through and memory is never touched. The walker does no caching: every translation with paging enabled walks both levels unless the first level faults. The control inputs and the directory base are sampled when a request is accepted.

Top module: `pt_walker`

## Requirements
- R1: On a successful translation, bits 11:0 of `rsp_paddr` equal bits 11:0 of the linear address.
- R2: The directory entry is read from `{dir_base[31:12], laddr[31:22], 2'b00}`. The low 12 bits of `ctl_dir_base` are ignored. The table entry is read from `{pde[31:12], laddr[21:12], 2'b00}`.
- R3: On success, `rsp_paddr = {pte[31:12], laddr[11:0]}`.
- R4: Unless both `ctl_pe` and `ctl_pg` are 1 at acceptance, the response gives `rsp_paddr` equal to the linear address with no fault, and no memory access is made.
- R5: Entry bit 0 means present. If it is 0 in the directory entry, the walk stops after that read. If it is 0 in the table entry, the walk stops after the second read. Either case reports a fault with `rsp_code[0]=0`.
- R6: Entry bit 2 means user-accessible and entry bit 1 means writable. A user access faults if bit 2 is 0 at either level. A user write faults if bit 1 is 0 at either level. A supervisor access to present entries never faults. A protection fault reports `rsp_code[0]=1`.
- R7: On a fault, `rsp_fault=1`, `rsp_code[1]` equals the write flag, `rsp_code[2]` equals the user flag, and `rsp_paddr=0`. Without a fault, `rsp_code=0`.
- R8: After a successful walk, bit 5 (accessed) is set in both entries. Bit 6 (dirty) is set in the table entry for a write. All other entry bits are written back unchanged.
- R9: An entry is written back only when its value changes, and a faulting walk writes nothing. The access order is: directory read, table read, directory write-back, table write-back.
- R10: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack`.
- R11: `req_ready` is high only when the walker is idle. A response stays on `rsp_valid` with stable data until `rsp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_pe | input | 1 | Protection-enable control bit |
| ctl_pg | input | 1 | Paging-enable control bit |
| ctl_dir_base | input | 32 | Directory base register; bits 31:12 used |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is in user mode |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation faulted |
| rsp_code | output | 3 | Fault cause: bit0 protection, bit1 write, bit2 user |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access complete; read data valid this cycle |
| mem_rdata | input | 32 | Entry value read |

## Verification
The assertions take it for granted that memory raises `mem_ack` for a single cycle, only while `mem_req` is high, and that `mem_rdata` is valid in that cycle. The stimulus meets this with a memory model that acknowledges each pending access exactly once, after a latency that cycles between zero and two waits. The control inputs are assumed to matter only at acceptance, and the bench changes them only between transactions. The requester is assumed never to raise `rsp_ready` before it wants the result, so holding the response back for several cycles is a legal pattern that the bench drives.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned PW_AW    = 32;
  localparam int unsigned PW_OFF_W = 12;
  localparam int unsigned PW_IDX_W = 10;

  // entry flag positions
  localparam int unsigned PW_E_P  = 0;
  localparam int unsigned PW_E_RW = 1;
  localparam int unsigned PW_E_US = 2;
  localparam int unsigned PW_E_A  = 5;
  localparam int unsigned PW_E_D  = 6;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DIR_RD = 3'd1,
    ST_TBL_RD = 3'd2,
    ST_DIR_WB = 3'd3,
    ST_TBL_WB = 3'd4,
    ST_RESP   = 3'd5
  } pw_state_e;

  typedef struct packed {
    logic user;
    logic write;
    logic prot;
  } pw_fcode_t;
endpackage

// File: rtl/pw_rst_sync.sv
module pw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned AW    = pw_pkg::PW_AW,
  parameter int unsigned OFF_W = pw_pkg::PW_OFF_W,
  parameter int unsigned IDX_W = pw_pkg::PW_IDX_W
) (
  input  logic [AW-OFF_W-1:0] dir_frame,
  input  logic [AW-OFF_W-1:0] tbl_frame,
  input  logic [AW-1:0]       laddr,
  input  logic                sel_tbl,
  output logic [AW-1:0]       ent_addr
);
  localparam int unsigned ESZ_LG = OFF_W - IDX_W;
  localparam int unsigned DIR_LO = AW - IDX_W;
  localparam int unsigned TBL_LO = OFF_W;

  logic [IDX_W-1:0] dir_idx, tbl_idx;

  assign dir_idx = laddr[DIR_LO +: IDX_W];
  assign tbl_idx = laddr[TBL_LO +: IDX_W];

  always_comb begin
    if (sel_tbl) ent_addr = {tbl_frame, tbl_idx, {ESZ_LG{1'b0}}};
    else         ent_addr = {dir_frame, dir_idx, {ESZ_LG{1'b0}}};
  end
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check #(
  parameter int unsigned AW = pw_pkg::PW_AW
) (
  input  logic [AW-1:0] entry,
  input  logic          is_leaf,
  input  logic          is_write,
  input  logic          is_user,
  output logic          present,
  output logic          perm_ok,
  output logic [AW-1:0] upd,
  output logic          changed
);
  import pw_pkg::*;

  logic user_deny, write_deny;

  always_comb begin
    present    = entry[PW_E_P];
    user_deny  = is_user && !entry[PW_E_US];
    write_deny = is_user && is_write && !entry[PW_E_RW];
    perm_ok    = !user_deny && !write_deny;
    upd        = entry;
    upd[PW_E_A] = 1'b1;
    if (is_leaf && is_write) upd[PW_E_D] = 1'b1;
    changed    = (upd != entry);
  end

  // R8: the written-back image always carries the accessed flag
  always_comb begin
    a_r8_upd_accessed: assert (upd[PW_E_A] === 1'b1 || $isunknown(entry));
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned AW    = pw_pkg::PW_AW,
  parameter int unsigned OFF_W = pw_pkg::PW_OFF_W,
  parameter int unsigned IDX_W = pw_pkg::PW_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_pe,
  input  logic          ctl_pg,
  input  logic [AW-1:0] ctl_dir_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_laddr,
  input  logic          req_write,
  input  logic          req_user,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_paddr,
  output logic          rsp_fault,
  output logic [2:0]    rsp_code,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata
);
  import pw_pkg::*;

  localparam int unsigned FRAME_W = AW - OFF_W;

  logic rst_s_n;

  pw_state_e st_q, st_d;
  logic [AW-1:0]      laddr_q;
  logic               wr_q, usr_q, pgon_q;
  logic [FRAME_W-1:0] base_q;
  logic [AW-1:0]      pde_q, pte_q;
  logic               pde_chg_q, pte_chg_q;
  logic [AW-1:0]      paddr_q, paddr_d;
  logic               fault_q, fault_d;
  pw_fcode_t          code_q, code_d;

  logic accept_en, pde_en, pte_en, rsp_ld;
  logic pg_now, sel_tbl;
  logic chk_present, chk_perm_ok, chk_changed;
  logic [AW-1:0] chk_upd;

  pw_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign sel_tbl = (st_q == ST_TBL_RD) || (st_q == ST_TBL_WB);

  pw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr_gen (
    .dir_frame (base_q),
    .tbl_frame (pde_q[AW-1:OFF_W]),
    .laddr     (laddr_q),
    .sel_tbl   (sel_tbl),
    .ent_addr  (mem_addr)
  );

  pw_entry_check #(.AW(AW)) u_entry_check (
    .entry    (mem_rdata),
    .is_leaf  (st_q == ST_TBL_RD),
    .is_write (wr_q),
    .is_user  (usr_q),
    .present  (chk_present),
    .perm_ok  (chk_perm_ok),
    .upd      (chk_upd),
    .changed  (chk_changed)
  );

  assign pg_now    = ctl_pe && ctl_pg;
  assign accept_en = (st_q == ST_IDLE) && req_valid;
  assign pde_en    = (st_q == ST_DIR_RD) && mem_ack;
  assign pte_en    = (st_q == ST_TBL_RD) && mem_ack;

  // next state and response values
  always_comb begin
    st_d    = st_q;
    rsp_ld  = 1'b0;
    paddr_d = '0;
    fault_d = 1'b0;
    code_d  = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (pg_now) begin
            st_d = ST_DIR_RD;
          end else begin
            st_d    = ST_RESP;
            rsp_ld  = 1'b1;
            paddr_d = req_laddr;
          end
        end
      end
      ST_DIR_RD, ST_TBL_RD: begin
        if (mem_ack) begin
          if (!chk_present || !chk_perm_ok) begin
            st_d    = ST_RESP;
            rsp_ld  = 1'b1;
            fault_d = 1'b1;
            code_d  = '{user: usr_q, write: wr_q, prot: chk_present};
          end else if (st_q == ST_DIR_RD) begin
            st_d = ST_TBL_RD;
          end else begin
            rsp_ld  = 1'b1;
            paddr_d = {mem_rdata[AW-1:OFF_W], laddr_q[OFF_W-1:0]};
            if (pde_chg_q)        st_d = ST_DIR_WB;
            else if (chk_changed) st_d = ST_TBL_WB;
            else                  st_d = ST_RESP;
          end
        end
      end
      ST_DIR_WB: begin
        if (mem_ack) st_d = pte_chg_q ? ST_TBL_WB : ST_RESP;
      end
      ST_TBL_WB: begin
        if (mem_ack) st_d = ST_RESP;
      end
      ST_RESP: begin
        if (rsp_ready) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) st_q <= ST_IDLE;
    else          st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      laddr_q <= '0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      pgon_q  <= 1'b0;
      base_q  <= '0;
    end else if (accept_en) begin
      laddr_q <= req_laddr;
      wr_q    <= req_write;
      usr_q   <= req_user;
      pgon_q  <= pg_now;
      base_q  <= ctl_dir_base[AW-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pde_q     <= '0;
      pde_chg_q <= 1'b0;
    end else if (pde_en) begin
      pde_q     <= chk_upd;
      pde_chg_q <= chk_changed;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      pte_q     <= '0;
      pte_chg_q <= 1'b0;
    end else if (pte_en) begin
      pte_q     <= chk_upd;
      pte_chg_q <= chk_changed;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      code_q  <= '0;
    end else if (rsp_ld) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
      code_q  <= code_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_paddr = paddr_q;
  assign rsp_fault = fault_q;
  assign rsp_code  = code_q;
  assign mem_req   = (st_q == ST_DIR_RD) || (st_q == ST_TBL_RD) ||
                     (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
  assign mem_we    = (st_q == ST_DIR_WB) || (st_q == ST_TBL_WB);
  assign mem_wdata = (st_q == ST_DIR_WB) ? pde_q : pte_q;

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_code)));

  a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    req_ready |-> (!rsp_valid && !mem_req));

  a_r4_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |-> pgon_q);

  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == laddr_q[OFF_W-1:0]));

  a_r7_fault_zero_pa: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_code[1] == wr_q && rsp_code[2] == usr_q));

  a_r8_wb_flags: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && mem_we) |-> (mem_wdata[PW_E_A] && mem_wdata[PW_E_P]));
endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_pe, ctl_pg;
  logic [31:0] ctl_dir_base;
  logic        req_valid, req_ready, req_write, req_user;
  logic [31:0] req_laddr;
  logic        rsp_valid, rsp_ready, rsp_fault;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_code;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int failures = 0;
  bit busy = 1'b0;
  bit mon_on = 1'b0;

  logic [31:0] mem_m [int unsigned];
  int unsigned log_addr[$];
  bit          log_we[$];
  logic [31:0] log_dat[$];
  int lat = 0;
  int wcnt = 0;

  always #5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .ctl_pe(ctl_pe), .ctl_pg(ctl_pg),
    .ctl_dir_base(ctl_dir_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_laddr(req_laddr), .req_write(req_write), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_code(rsp_code), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rdm(input int unsigned a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: one ack per pending access, latency 0..2 waits
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        lat = (lat + 1) % 3;
        log_addr.push_back(mem_addr);
        log_we.push_back(mem_we);
        log_dat.push_back(mem_wdata);
        if (mem_we) mem_m[mem_addr] = mem_wdata;
        else        mem_rdata <= rdm(mem_addr);
        mem_ack <= 1'b1;
      end
    end
  end

  // every-clock comparison of handshake state against the model's busy flag (R11, R4)
  always @(negedge clk) begin
    if (mon_on) begin
      if (!busy) chk(req_ready && !rsp_valid && !mem_req, "R11", "idle outputs",
                     {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
      else       chk(!req_ready, "R11", "ready while busy", {31'b0, req_ready}, 32'h0);
    end
  end

  task automatic xlate(input logic [31:0] la, input bit w, input bit u,
                       input int hold, input string tag);
    logic [31:0] ep, pa, ta, pde, pte, npde, npte;
    bit ef;
    logic [2:0] ec;
    int unsigned xa[$];
    bit xw[$];
    logic [31:0] xd[$];
    int n;
    ef = 1'b0; ec = 3'b000; ep = 32'h0;
    if (!(ctl_pe && ctl_pg)) ep = la;
    else begin
      pa  = {ctl_dir_base[31:12], la[31:22], 2'b00};
      pde = rdm(pa);
      xa.push_back(pa); xw.push_back(1'b0); xd.push_back(32'h0);
      if (!pde[0]) begin ef = 1; ec = {u, w, 1'b0}; end
      else if ((u && !pde[2]) || (u && w && !pde[1])) begin ef = 1; ec = {u, w, 1'b1}; end
      else begin
        ta  = {pde[31:12], la[21:12], 2'b00};
        pte = rdm(ta);
        xa.push_back(ta); xw.push_back(1'b0); xd.push_back(32'h0);
        if (!pte[0]) begin ef = 1; ec = {u, w, 1'b0}; end
        else if ((u && !pte[2]) || (u && w && !pte[1])) begin ef = 1; ec = {u, w, 1'b1}; end
        else begin
          ep   = {pte[31:12], la[11:0]};
          npde = pde | 32'h20;
          npte = pte | 32'h20 | (w ? 32'h40 : 32'h0);
          if (npde != pde) begin xa.push_back(pa); xw.push_back(1'b1); xd.push_back(npde); end
          if (npte != pte) begin xa.push_back(ta); xw.push_back(1'b1); xd.push_back(npte); end
        end
      end
    end
    log_addr.delete(); log_we.delete(); log_dat.delete();

    @(negedge clk);
    req_laddr = la; req_write = w; req_user = u; req_valid = 1'b1;
    @(posedge clk);
    busy = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    chk(rsp_valid, tag, "response timeout", {31'b0, rsp_valid}, 32'h1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == ep, "R11", "held response", rsp_paddr, ep);
    end
    chk(rsp_fault == ef, tag, "fault", {31'b0, rsp_fault}, {31'b0, ef});
    chk(rsp_code == ec, tag, "code", {29'b0, rsp_code}, {29'b0, ec});
    chk(rsp_paddr == ep, tag, "paddr", rsp_paddr, ep);
    rsp_ready = 1'b1;
    @(posedge clk);
    busy = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid, "R11", "response dropped", {31'b0, rsp_valid}, 32'h0);
    chk(log_addr.size() == xa.size(), "R9", {tag, " access count"}, log_addr.size(), xa.size());
    if (log_addr.size() == xa.size())
      for (int i = 0; i < xa.size(); i++) begin
        chk(log_addr[i] == xa[i] && log_we[i] == xw[i], "R2", {tag, " access addr/dir"}, log_addr[i], xa[i]);
        if (xw[i]) chk(log_dat[i] == xd[i], "R8", {tag, " written entry"}, log_dat[i], xd[i]);
      end
  endtask

  function automatic logic [31:0] la_of(input int d, input int t, input int o);
    return (32'(d) << 22) | (32'(t) << 12) | 32'(o);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_pe = 1'b1; ctl_pg = 1'b0; ctl_dir_base = 32'h0010_0ABC;
    req_valid = 1'b0; req_laddr = '0; req_write = 1'b0; req_user = 1'b0;
    rsp_ready = 1'b0; mem_rdata = '0;
    // directory at 0x100000
    mem_m[32'h0010_0000] = 32'h0010_1007;
    mem_m[32'h0010_0004] = 32'h0010_2006;
    mem_m[32'h0010_0008] = 32'h0010_3003;
    mem_m[32'h0010_000C] = 32'h0010_4005;
    mem_m[32'h0010_0010] = 32'h0010_1027;
    mem_m[32'h0010_1000] = 32'h0020_0007;
    mem_m[32'h0010_1004] = 32'h0020_1006;
    mem_m[32'h0010_1008] = 32'h0020_2005;
    mem_m[32'h0010_100C] = 32'h0020_3063;
    mem_m[32'h0010_1010] = 32'h0020_4067;
    mem_m[32'h0010_3000] = 32'h0030_0007;
    mem_m[32'h0010_4000] = 32'h0040_0007;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R11", "reset state",
        {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
    mon_on = 1'b1;

    xlate(32'hDEAD_BEEF, 1'b1, 1'b1, 0, "R4 pg off");
    ctl_pe = 1'b0; ctl_pg = 1'b1;
    xlate(32'h1234_5678, 1'b0, 1'b0, 0, "R4 pe off");
    ctl_pe = 1'b1;
    xlate(la_of(0, 0, 12'h123), 1'b0, 1'b1, 0, "R3 R1 first read");
    xlate(la_of(0, 0, 12'hFFF), 1'b0, 1'b1, 0, "R9 flags already set");
    xlate(la_of(0, 0, 12'h004), 1'b1, 1'b1, 0, "R8 dirty on write");
    xlate(la_of(1, 0, 12'h010), 1'b0, 1'b1, 0, "R5 R7 dir absent");
    xlate(la_of(0, 1, 12'h020), 1'b1, 1'b0, 0, "R5 R7 table absent");
    xlate(la_of(2, 0, 12'h030), 1'b0, 1'b1, 0, "R6 user to supervisor dir");
    xlate(la_of(2, 0, 12'h040), 1'b0, 1'b0, 0, "R6 supervisor ok");
    xlate(la_of(3, 0, 12'h050), 1'b1, 1'b1, 0, "R6 user write ro dir");
    xlate(la_of(3, 0, 12'h060), 1'b1, 1'b0, 0, "R6 supervisor write ro");
    xlate(la_of(0, 2, 12'h070), 1'b1, 1'b1, 0, "R6 R9 user write ro table");
    xlate(la_of(4, 3, 12'h080), 1'b0, 1'b1, 0, "R6 user to supervisor table");
    xlate(la_of(4, 4, 12'hABC), 1'b1, 1'b0, 5, "R11 R10 held result");
    xlate(la_of(0, 2, 12'h090), 1'b0, 1'b1, 3, "R8 R3 user read ro table");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule